// File: doc/BRIEF.md
# Byte-stream to word-program write merger

This block sits in front of a flash word-program engine. Software-facing logic hands it a byte start address and a byte count, then streams the bytes in with a valid/ready handshake. The block groups the stream into full bus-width words and sends each one to the program engine through a request/acknowledge handshake. The engine returns a two-bit result for every word.

A transfer may start and end anywhere inside a word. When a word is only partly covered by the requested range, the block first fetches that word's current contents through a read port. It keeps the flash bytes in the lanes outside the range, so neighbouring data is written back unchanged. Bytes are placed big-endian: the lowest address goes in the most significant lane. The first word that comes back with a non-zero result ends the whole transfer, and that code is reported.

Top module: `flash_wr_merge`

## Requirements
- R1: After a synchronous reset, `busy_o`, `done_o`, `rd_req_o`, `pg_req_o`, `src_ready_o` are low and `result_o` is 0.
- R2: A start taken with a byte count of zero raises `done_o` one cycle later with result 0, and issues no read, no word write and no source handshake.
- R3: The first word is written at the start address with its low log2(WORD_BYTES) bits cleared. Each further word is written WORD_BYTES bytes higher. `pg_addr_o` is always word aligned.
- R4: Within `pg_data_o`, the byte for the lowest address of the word occupies bits [W-1:W-8], and each higher address takes the next lower byte.
- R5: A lane that lies before the start offset (first word) or after the last requested byte (last word) carries the byte that `rd_data_i` returned for that lane. Those flash bytes are written back unchanged.
- R6: A word is read through `rd_req_o`/`rd_addr_o` exactly once, before it is written, if and only if at least one of its lanes lies outside the range. The request drops after the cycle in which `rd_valid_i` is seen.
- R7: Source bytes are accepted only for lanes inside the range, in address order. A full transfer accepts exactly the byte count.
- R8: A transfer that succeeds issues ceil((offset + count) / WORD_BYTES) word writes.
- R9: A non-zero `pg_res_i` (1 timeout, 2 not erased) ends the transfer. `done_o` rises the next cycle with that code, and no further word or source byte is taken.
- R10: When every word returns 0, the transfer ends with `done_o` and result 0.
- R11: `pg_req_o` stays high with stable `pg_addr_o` and `pg_data_o` until `pg_ack_i` is seen.
- R12: A `start_i` pulse while `busy_o` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a transfer (taken when idle) |
| start_addr_i | input | ADDR_W | Byte start address |
| byte_cnt_i | input | CNT_W | Number of bytes to write |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| result_o | output | 2 | Final result, held until the next start |
| src_valid_i | input | 1 | Source byte valid |
| src_data_i | input | 8 | Source byte |
| src_ready_o | output | 1 | Source byte accepted when valid |
| rd_req_o | output | 1 | Existing-word read request |
| rd_addr_o | output | ADDR_W | Word-aligned read address |
| rd_valid_i | input | 1 | Read data valid |
| rd_data_i | input | 8*WORD_BYTES | Existing word contents |
| pg_req_o | output | 1 | Word program request |
| pg_addr_o | output | ADDR_W | Word-aligned program address |
| pg_data_o | output | 8*WORD_BYTES | Merged word to program |
| pg_ack_i | input | 1 | Program engine finished the word |
| pg_res_i | input | 2 | Program result (0 ok, 1 timeout, 2 not erased) |

## Verification
The bench builds the block with WORD_BYTES=4, ADDR_W=16 and CNT_W=12. Four lanes bring all of these within reach: the three non-zero start offsets, transfers that begin and end inside one word, and trailing partial words of every length. The read, source and program handshakes are stalled at random, so held requests and back-pressure are covered. Failures are injected on the first and on later words with both error codes.

// File: rtl/fwm_pkg.sv
package fwm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PLAN,
    ST_READ,
    ST_FILL,
    ST_PROG
  } fwm_state_e;

  localparam logic [1:0] RES_OK = 2'd0;
endpackage

// File: rtl/fwm_span.sv
// Per-word lane coverage: which lanes take a source byte, whether the word
// needs a read-merge, how far the remaining count drops, and whether this
// word is the last one.
module fwm_span #(
  parameter int WORD_BYTES = 4,
  parameter int CNT_W      = 12,
  localparam int LB        = $clog2(WORD_BYTES)
) (
  input  logic [LB-1:0]         lead_i,
  input  logic [CNT_W-1:0]      rem_i,
  output logic [WORD_BYTES-1:0] lane_en_o,
  output logic                  partial_o,
  output logic                  last_o,
  output logic [CNT_W-1:0]      step_o
);
  for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
    localparam int unsigned LANE = g;
    assign lane_en_o[g] = (lead_i <= LB'(LANE)) &&
                          ((CNT_W'(LANE) - CNT_W'(lead_i)) < rem_i);
  end

  assign step_o    = CNT_W'(WORD_BYTES) - CNT_W'(lead_i);
  assign partial_o = ~&lane_en_o;
  assign last_o    = (rem_i <= step_o);
endmodule

// File: rtl/fwm_pack.sv
// Word assembly register: loaded whole from a flash read, then patched one
// lane at a time, lane 0 being the most significant byte.
module fwm_pack #(
  parameter int WORD_BYTES = 4,
  localparam int LB        = $clog2(WORD_BYTES),
  localparam int WORD_W    = 8 * WORD_BYTES
) (
  input  logic              clk,
  input  logic              load_i,
  input  logic [WORD_W-1:0] load_word_i,
  input  logic              put_i,
  input  logic [LB-1:0]     put_lane_i,
  input  logic [7:0]        put_byte_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] word_q;

  always_ff @(posedge clk) begin
    if (load_i) begin
      word_q <= load_word_i;
    end else if (put_i) begin
      for (int i = 0; i < WORD_BYTES; i++) begin
        if (put_lane_i == LB'(i)) word_q[(WORD_BYTES-1-i)*8 +: 8] <= put_byte_i;
      end
    end
  end

  assign word_o = word_q;
endmodule

// File: rtl/fwm_ctrl.sv
// Sequencer: plan -> optional read -> lane fill -> program, repeated per word.
module fwm_ctrl
  import fwm_pkg::*;
#(
  parameter int WORD_BYTES = 4,
  parameter int ADDR_W     = 16,
  parameter int CNT_W      = 12,
  localparam int LB        = $clog2(WORD_BYTES)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start_i,
  input  logic [ADDR_W-1:0]     start_addr_i,
  input  logic [CNT_W-1:0]      byte_cnt_i,
  input  logic [WORD_BYTES-1:0] lane_en_i,
  input  logic                  partial_i,
  input  logic                  last_i,
  input  logic [CNT_W-1:0]      step_i,
  input  logic                  src_valid_i,
  input  logic                  rd_valid_i,
  input  logic                  pg_ack_i,
  input  logic [1:0]            pg_res_i,
  output fwm_state_e            state_o,
  output logic [LB-1:0]         lead_o,
  output logic [CNT_W-1:0]      rem_o,
  output logic [LB-1:0]         lane_o,
  output logic [ADDR_W-1:0]     addr_o,
  output logic                  done_o,
  output logic [1:0]            result_o
);
  fwm_state_e        state_q;
  logic [LB-1:0]     lead_q;
  logic [CNT_W-1:0]  rem_q;
  logic [LB-1:0]     lane_q;
  logic [ADDR_W-1:0] addr_q;
  logic              done_q;
  logic [1:0]        res_q;
  logic              lane_step;

  assign lane_step = !lane_en_i[lane_q] || src_valid_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      lead_q  <= '0;
      rem_q   <= '0;
      lane_q  <= '0;
      addr_q  <= '0;
      done_q  <= 1'b0;
      res_q   <= RES_OK;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            res_q <= RES_OK;
            if (byte_cnt_i == '0) begin
              done_q <= 1'b1;
            end else begin
              addr_q  <= {start_addr_i[ADDR_W-1:LB], LB'(0)};
              lead_q  <= start_addr_i[LB-1:0];
              rem_q   <= byte_cnt_i;
              state_q <= ST_PLAN;
            end
          end
        end
        ST_PLAN: begin
          lane_q  <= '0;
          state_q <= partial_i ? ST_READ : ST_FILL;
        end
        ST_READ: begin
          if (rd_valid_i) state_q <= ST_FILL;
        end
        ST_FILL: begin
          if (lane_step) begin
            lane_q <= lane_q + LB'(1);
            if (lane_q == LB'(WORD_BYTES - 1)) state_q <= ST_PROG;
          end
        end
        ST_PROG: begin
          if (pg_ack_i) begin
            if (pg_res_i != RES_OK) begin
              res_q   <= pg_res_i;
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else if (last_i) begin
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              addr_q  <= addr_q + ADDR_W'(WORD_BYTES);
              rem_q   <= rem_q - step_i;
              lead_q  <= '0;
              state_q <= ST_PLAN;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o  = state_q;
  assign lead_o   = lead_q;
  assign rem_o    = rem_q;
  assign lane_o   = lane_q;
  assign addr_o   = addr_q;
  assign done_o   = done_q;
  assign result_o = res_q;
endmodule

// File: rtl/flash_wr_merge.sv
module flash_wr_merge
  import fwm_pkg::*;
#(
  parameter int WORD_BYTES = 4,
  parameter int ADDR_W     = 16,
  parameter int CNT_W      = 12,
  localparam int LB        = $clog2(WORD_BYTES),
  localparam int WORD_W    = 8 * WORD_BYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [CNT_W-1:0]  byte_cnt_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [1:0]        result_o,
  input  logic              src_valid_i,
  input  logic [7:0]        src_data_i,
  output logic              src_ready_o,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_valid_i,
  input  logic [WORD_W-1:0] rd_data_i,
  output logic              pg_req_o,
  output logic [ADDR_W-1:0] pg_addr_o,
  output logic [WORD_W-1:0] pg_data_o,
  input  logic              pg_ack_i,
  input  logic [1:0]        pg_res_i
);
  fwm_state_e            state;
  logic [LB-1:0]         lead;
  logic [CNT_W-1:0]      rem;
  logic [LB-1:0]         lane;
  logic [ADDR_W-1:0]     waddr;
  logic [WORD_BYTES-1:0] lane_en;
  logic                  partial;
  logic                  last;
  logic [CNT_W-1:0]      step;
  logic [WORD_W-1:0]     word;

  fwm_span #(.WORD_BYTES(WORD_BYTES), .CNT_W(CNT_W)) span_i (
    .lead_i    (lead),
    .rem_i     (rem),
    .lane_en_o (lane_en),
    .partial_o (partial),
    .last_o    (last),
    .step_o    (step)
  );

  fwm_ctrl #(.WORD_BYTES(WORD_BYTES), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) ctrl_i (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .start_addr_i (start_addr_i),
    .byte_cnt_i   (byte_cnt_i),
    .lane_en_i    (lane_en),
    .partial_i    (partial),
    .last_i       (last),
    .step_i       (step),
    .src_valid_i  (src_valid_i),
    .rd_valid_i   (rd_valid_i),
    .pg_ack_i     (pg_ack_i),
    .pg_res_i     (pg_res_i),
    .state_o      (state),
    .lead_o       (lead),
    .rem_o        (rem),
    .lane_o       (lane),
    .addr_o       (waddr),
    .done_o       (done_o),
    .result_o     (result_o)
  );

  fwm_pack #(.WORD_BYTES(WORD_BYTES)) pack_i (
    .clk         (clk),
    .load_i      (rd_req_o && rd_valid_i),
    .load_word_i (rd_data_i),
    .put_i       (src_ready_o && src_valid_i),
    .put_lane_i  (lane),
    .put_byte_i  (src_data_i),
    .word_o      (word)
  );

  assign busy_o      = (state != ST_IDLE);
  assign src_ready_o = (state == ST_FILL) && lane_en[lane];
  assign rd_req_o    = (state == ST_READ);
  assign rd_addr_o   = waddr;
  assign pg_req_o    = (state == ST_PROG);
  assign pg_addr_o   = waddr;
  assign pg_data_o   = word;
endmodule

// File: rtl/fwm_checker.sv
module fwm_checker #(
  parameter int WORD_BYTES = 4,
  parameter int ADDR_W     = 16,
  parameter int CNT_W      = 12,
  localparam int LB        = $clog2(WORD_BYTES),
  localparam int WORD_W    = 8 * WORD_BYTES
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic [CNT_W-1:0]  byte_cnt_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [1:0]        result_o,
  input logic              src_ready_o,
  input logic              rd_req_o,
  input logic              rd_valid_i,
  input logic              pg_req_o,
  input logic [ADDR_W-1:0] pg_addr_o,
  input logic [WORD_W-1:0] pg_data_o,
  input logic              pg_ack_i,
  input logic [1:0]        pg_res_i
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!busy_o && !pg_req_o && !rd_req_o && !src_ready_o));

  p_zero_len_r2: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o && byte_cnt_i == '0) |=> (done_o && result_o == 2'd0 && !busy_o));

  p_word_align_r3: assert property (@(posedge clk) disable iff (rst)
    pg_req_o |-> (pg_addr_o[LB-1:0] == '0));

  p_single_read_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_req_o && rd_valid_i) |=> !rd_req_o);

  p_abort_r9: assert property (@(posedge clk) disable iff (rst)
    (pg_req_o && pg_ack_i && pg_res_i != 2'd0) |=>
      (done_o && result_o == $past(pg_res_i) && !busy_o));

  p_req_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (pg_req_o && !pg_ack_i) |=> (pg_req_o && $stable(pg_addr_o) && $stable(pg_data_o)));
endmodule

bind flash_wr_merge fwm_checker #(
  .WORD_BYTES (WORD_BYTES),
  .ADDR_W     (ADDR_W),
  .CNT_W      (CNT_W)
) chk_i (
  .clk         (clk),
  .rst         (rst),
  .start_i     (start_i),
  .byte_cnt_i  (byte_cnt_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .result_o    (result_o),
  .src_ready_o (src_ready_o),
  .rd_req_o    (rd_req_o),
  .rd_valid_i  (rd_valid_i),
  .pg_req_o    (pg_req_o),
  .pg_addr_o   (pg_addr_o),
  .pg_data_o   (pg_data_o),
  .pg_ack_i    (pg_ack_i),
  .pg_res_i    (pg_res_i)
);

// File: tb/flash_wr_merge_tb_top.sv
module flash_wr_merge_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WB         = 4;
  localparam int AW         = 16;
  localparam int CW         = 12;
  localparam int MEM_BYTES  = 512;
  localparam int WW         = 8 * WB;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic [AW-1:0] start_addr_i = '0;
  logic [CW-1:0] byte_cnt_i = '0;
  logic          busy_o, done_o, src_ready_o, rd_req_o, pg_req_o;
  logic [1:0]    result_o;
  logic          src_valid_i = 1'b0;
  logic [7:0]    src_data_i = '0;
  logic [AW-1:0] rd_addr_o, pg_addr_o;
  logic          rd_valid_i = 1'b0;
  logic [WW-1:0] rd_data_i = '0;
  logic [WW-1:0] pg_data_o;
  logic          pg_ack_i = 1'b0;
  logic [1:0]    pg_res_i = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_wr_merge #(.WORD_BYTES(WB), .ADDR_W(AW), .CNT_W(CW)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .start_addr_i(start_addr_i),
    .byte_cnt_i(byte_cnt_i), .busy_o(busy_o), .done_o(done_o), .result_o(result_o),
    .src_valid_i(src_valid_i), .src_data_i(src_data_i), .src_ready_o(src_ready_o),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_valid_i(rd_valid_i),
    .rd_data_i(rd_data_i), .pg_req_o(pg_req_o), .pg_addr_o(pg_addr_o),
    .pg_data_o(pg_data_o), .pg_ack_i(pg_ack_i), .pg_res_i(pg_res_i)
  );

  int n_checks = 0;
  int n_fail   = 0;
  logic [7:0] flash_mem [MEM_BYTES];
  logic [7:0] exp_mem   [MEM_BYTES];
  logic [7:0] src_buf   [64];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_xfer(input int addr, input int cnt, input int fail_word,
                          input int fail_code, input bit poke);
    int a0, lead, rem, j, boff, n, e_words, e_reads, e_bytes, e_res;
    int words, reads, sidx, res, iter, bad;
    bit fin;
    for (int b = 0; b < 64; b++) src_buf[b] = 8'($urandom);
    for (int b = 0; b < MEM_BYTES; b++) exp_mem[b] = flash_mem[b];
    // Expected outcome from the requirements
    a0 = addr - addr % WB; lead = addr % WB; rem = cnt; j = 0; boff = 0;
    e_words = 0; e_reads = 0; e_bytes = 0; e_res = 0;
    while (rem > 0) begin
      n = WB - lead;
      if (n > rem) n = rem;
      e_words++;
      if (lead != 0 || n < WB) e_reads++;
      e_bytes += n;
      if (j == fail_word) begin
        e_res = fail_code;
        break;
      end
      for (int k = 0; k < n; k++) exp_mem[a0 + j*WB + lead + k] = src_buf[boff + k];
      boff += n; rem -= (WB - lead); lead = 0; j++;
    end
    // Drive
    @(negedge clk);
    start_i = 1'b1; start_addr_i = AW'(addr); byte_cnt_i = CW'(cnt);
    words = 0; reads = 0; sidx = 0; res = -1; iter = 0; fin = 1'b0;
    while (!fin) begin
      @(negedge clk);
      iter++;
      start_i = (poke && iter == 3);
      if (poke && iter == 3) begin
        start_addr_i = AW'(addr + 100);
        byte_cnt_i   = CW'(5);
      end
      src_valid_i = 1'b0; rd_valid_i = 1'b0; pg_ack_i = 1'b0; pg_res_i = '0;
      if (done_o) begin
        res = int'(result_o);
        fin = 1'b1;
      end else if (iter > 2000) begin
        chk(1'b0, "watchdog", iter, 2000);
        fin = 1'b1;
      end else begin
        if ($urandom % 4 != 0) begin
          src_valid_i = 1'b1;
          src_data_i  = src_buf[sidx % 64];
          if (src_ready_o) sidx++;
        end
        if (rd_req_o && ($urandom % 2 == 0)) begin
          logic [WW-1:0] w;
          w = '0;
          for (int l = 0; l < WB; l++) w = {w[WW-9:0], flash_mem[int'(rd_addr_o) + l]};
          rd_data_i  = w;
          rd_valid_i = 1'b1;
          reads++;
        end
        if (pg_req_o && ($urandom % 2 == 0)) begin
          // R3: each word lands one word above the previous one
          chk(int'(pg_addr_o) == a0 + words*WB, "R3 word address", int'(pg_addr_o), a0 + words*WB);
          pg_ack_i = 1'b1;
          pg_res_i = (words == fail_word) ? 2'(fail_code) : 2'd0;
          if (words != fail_word)
            for (int l = 0; l < WB; l++)
              flash_mem[int'(pg_addr_o) + l] = pg_data_o[(WB-1-l)*8 +: 8];
          words++;
        end
      end
    end
    start_i = 1'b0; src_valid_i = 1'b0;
    if (e_res != 0) chk(res == e_res, "R9 abort code", res, e_res);
    else            chk(res == 0, "R10 result ok", res, 0);
    chk(words == e_words, (cnt == 0) ? "R2 no words" : "R8 word count", words, e_words);
    chk(reads == e_reads, "R6 read count", reads, e_reads);
    chk(sidx == e_bytes, "R7 bytes taken", sidx, e_bytes);
    bad = 0;
    for (int b = 0; b < MEM_BYTES; b++) if (flash_mem[b] !== exp_mem[b]) bad++;
    chk(bad == 0, "R4 R5 merged flash image", bad, 0);
    if (poke) chk(words == e_words && bad == 0, "R12 start while busy", words, e_words);
    @(negedge clk);
    chk(!busy_o && !done_o, "R10 returns idle", int'(busy_o), 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int b = 0; b < MEM_BYTES; b++) flash_mem[b] = 8'($urandom);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy_o && !done_o && !rd_req_o && !pg_req_o && !src_ready_o && result_o == 2'd0,
        "R1 reset state", int'(busy_o), 0);
    run_xfer(40, 0, -1, 0, 1'b0);   // R2 zero length
    run_xfer(64, 16, -1, 0, 1'b0);  // aligned, no reads
    run_xfer(65, 2, -1, 0, 1'b0);   // both edges in one word
    run_xfer(67, 1, -1, 0, 1'b0);   // last lane only
    run_xfer(102, 9, -1, 0, 1'b0);  // lead and tail partial
    run_xfer(129, 20, 0, 2, 1'b0);  // R9 fail on first word
    run_xfer(200, 30, 2, 1, 1'b0);  // R9 fail on a later word
    run_xfer(250, 25, -1, 0, 1'b1); // R12 start while busy
    for (int t = 0; t < 40; t++) begin
      int fw;
      fw = ($urandom % 4 == 0) ? int'($urandom % 3) : -1;
      run_xfer(int'($urandom % 300), int'($urandom % 40), fw, 1 + int'($urandom % 2), 1'b0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule